// File: doc/BRIEF.md
# Supply Threshold Level Search

This block finds the highest threshold setting that a monitored analog quantity lies above. It drives a level code to an external comparator that can only judge one threshold per run. It pulses the comparator's start and waits until the comparator's busy flag falls. It then reads the pass/fail result. After a fail it lowers the code by one and runs the comparator again. After a pass it stops and reports the code.

A host pulses `start_i`. When the search ends, the block returns a single-cycle `done_o` together with a held result code and an underflow flag. The search is linear from the top: it begins at the highest code and runs one comparison per step. If the code would fall to zero, the search gives up, reports code zero and raises the underflow flag. All pins are plain control and status pins with no back-pressure. The host must take the result from `code_o` and `underflow_o`, which stay unchanged until the next search completes.

Top module: `thr_level_search`

## Requirements
- R1: During and after synchronous active-low reset, `code_o` is 0, `underflow_o` is 0, `done_o` is 0 and `cmp_start_o` is 0.
- R2: A start request accepted while idle makes the first comparison run at level code all-ones (4'hF with the default width).
- R3: `cmp_start_o` is high for exactly one cycle per comparison. `level_o` holds the same value in the cycle before the pulse and during it.
- R4: While `cmp_busy_i` is high, the block neither reads the result nor moves on: `level_o` stays unchanged and `done_o` stays low.
- R5: `cmp_result_i` high (input above the current level), sampled once busy is low, ends the search. `done_o` pulses, `code_o` takes the current level and `underflow_o` is 0.
- R6: `cmp_result_i` low at a level above 1 lowers the level by exactly one and starts a new comparison. The number of comparisons for a passing search at code c is therefore 16 - c.
- R7: `cmp_result_i` low at level 1 ends the search with `underflow_o` = 1 and `code_o` = 0, after 15 comparisons.
- R8: `done_o` is a one-cycle pulse per search. `code_o` and `underflow_o` hold their values until the next search ends.
- R9: A start request that arrives while a search is in progress has no effect: no restart, no extra comparisons and no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Search request, sampled while idle |
| done_o | output | 1 | One-cycle pulse at search end |
| level_o | output | 4 | Threshold code driven to the comparator |
| cmp_start_o | output | 1 | One-cycle comparator start pulse |
| cmp_busy_i | input | 1 | Comparator conversion in progress |
| cmp_result_i | input | 1 | 1 = input above current level |
| code_o | output | 4 | Latched final code (0 on underflow) |
| underflow_o | output | 1 | Latched: search ran below level 1 |

## Verification
The hardest situation to reach is a start request that lands in the middle of a long search, at the very cycles where the comparator is busy or a step is being prepared. The stimulus runs searches with randomized input magnitudes and random comparator latencies, including zero latency. During each search it inserts extra start pulses at fixed cycle offsets. A bench monitor counts comparator starts and tracks the level sequence, which exposes any restart or skipped step. Directed cases cover a pass at the top code, a pass at code 1, and underflow at both zero and level-1 magnitudes.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } thr_state_t;
endpackage

// File: rtl/thr_level_ctr.sv
module thr_level_ctr #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_max,
  input  logic             dec,
  output logic [LVL_W-1:0] level,
  output logic             at_floor
);
  localparam logic [LVL_W-1:0] LVL_MAX   = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_FLOOR = LVL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)        level <= '0;
    else if (load_max) level <= LVL_MAX;
    else if (dec)      level <= level - LVL_W'(1);
  end

  assign at_floor = (level == LVL_FLOOR);

  assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load_max) |=> (level == $past(level) - LVL_W'(1)));
endmodule

// File: rtl/thr_seq_fsm.sv
module thr_seq_fsm
  import thr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic result,
  input  logic at_floor,
  output logic load_max,
  output logic dec,
  output logic cmp_start,
  output logic fin_pass,
  output logic fin_fail
);
  thr_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt      = state;
    load_max = 1'b0;
    dec      = 1'b0;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        load_max = 1'b1;
        nxt      = ST_SETUP;
      end
      ST_SETUP: nxt = ST_PULSE;
      ST_PULSE: nxt = ST_WAIT;
      ST_WAIT: if (!busy) begin
        if (result) begin
          fin_pass = 1'b1;
          nxt      = ST_IDLE;
        end else if (at_floor) begin
          fin_fail = 1'b1;
          nxt      = ST_IDLE;
        end else begin
          dec = 1'b1;
          nxt = ST_SETUP;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cmp_start = (state == ST_PULSE);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start |=> !cmp_start);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !load_max);
endmodule

// File: rtl/thr_result_reg.sv
module thr_result_reg #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_pass,
  input  logic             fin_fail,
  input  logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] code,
  output logic             underflow,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code      <= '0;
      underflow <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= fin_pass | fin_fail;
      if (fin_pass) begin
        code      <= level;
        underflow <= 1'b0;
      end else if (fin_fail) begin
        code      <= '0;
        underflow <= 1'b1;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(code) && $stable(underflow)));
  assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (code == '0));
endmodule

// File: rtl/thr_level_search.sv
module thr_level_search #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             done_o,
  output logic [LVL_W-1:0] level_o,
  output logic             cmp_start_o,
  input  logic             cmp_busy_i,
  input  logic             cmp_result_i,
  output logic [LVL_W-1:0] code_o,
  output logic             underflow_o
);
  logic load_max, dec, at_floor, fin_pass, fin_fail;

  thr_level_ctr #(.LVL_W(LVL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_max(load_max), .dec(dec),
    .level(level_o), .at_floor(at_floor)
  );

  thr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(cmp_busy_i),
    .result(cmp_result_i), .at_floor(at_floor), .load_max(load_max),
    .dec(dec), .cmp_start(cmp_start_o), .fin_pass(fin_pass), .fin_fail(fin_fail)
  );

  thr_result_reg #(.LVL_W(LVL_W)) u_res (
    .clk(clk), .rst_n(rst_n), .fin_pass(fin_pass), .fin_fail(fin_fail),
    .level(level_o), .code(code_o), .underflow(underflow_o), .done(done_o)
  );

  assert_level_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start_o |-> $stable(level_o));
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_busy_i && !cmp_start_o) |=> ($stable(level_o) && !done_o));
  assert_first_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_max |=> (level_o == {LVL_W{1'b1}}));
  assert_pass_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_pass |=> (code_o == $past(level_o) && !underflow_o));
endmodule

// File: tb/thr_level_search_tb.sv
module thr_level_search_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, cmp_start_o, underflow_o;
  logic [3:0] level_o, code_o;
  logic cmp_busy_i = 1'b0;
  logic cmp_result_i = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int vin = 0, lat = 0, cnt = 0;
  bit in_search = 0;
  int n_starts = 0, n_done = 0, exp_lvl = 15;
  int bad_seq = 0, bad_stab = 0, bad_pulse = 0;
  logic prev_cs = 1'b0;
  logic [3:0] prev_lvl = 4'd0, lvl_at_start = 4'd0;

  always #4 clk = ~clk;

  thr_level_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .level_o(level_o), .cmp_start_o(cmp_start_o), .cmp_busy_i(cmp_busy_i),
    .cmp_result_i(cmp_result_i), .code_o(code_o), .underflow_o(underflow_o)
  );

  // behavioural comparator: result = input above level, busy for lat cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      cmp_busy_i <= 1'b0;
      cnt <= 0;
    end else if (cmp_start_o) begin
      cmp_result_i <= (vin > int'(level_o));
      cmp_busy_i <= (lat > 0);
      cnt <= lat;
    end else if (cmp_busy_i) begin
      cnt <= cnt - 1;
      if (cnt <= 1) cmp_busy_i <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (in_search) begin
      if (cmp_start_o) begin
        n_starts++;
        if (int'(level_o) != exp_lvl) bad_seq++;
        if (level_o != prev_lvl) bad_stab++;
        exp_lvl--;
        lvl_at_start = level_o;
      end
      if (cmp_busy_i && !cmp_start_o && (level_o != lvl_at_start || done_o)) bad_stab++;
      if (prev_cs && cmp_start_o) bad_pulse++;
      if (done_o) n_done++;
    end
    prev_cs = cmp_start_o;
    prev_lvl = level_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_code(input int v);
    for (int c = 15; c >= 1; c--) if (v > c) return c;
    return 0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_search(input int v, input int l, input bit inject);
    int ec, es, k;
    bit seen;
    vin = v; lat = l;
    n_starts = 0; n_done = 0; exp_lvl = 15;
    bad_seq = 0; bad_stab = 0; bad_pulse = 0;
    @(negedge clk);
    in_search = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    k = 0;
    while (!seen && k < 2000) begin
      if (done_o) seen = 1;
      else begin
        start_i = inject && (k == 3 || k == 7 || k == 20);
        @(negedge clk);
        start_i = 1'b0;
        k++;
      end
    end
    ec = exp_code(v);
    es = (ec == 0) ? 15 : 16 - ec;
    check(seen, "R5 done seen", int'(seen), 1);
    check(int'(code_o) == ec, (ec == 0) ? "R7 code" : "R5 code", int'(code_o), ec);
    check(underflow_o == (ec == 0), (ec == 0) ? "R7 underflow" : "R5 underflow", int'(underflow_o), int'(ec == 0));
    check(n_starts == es, inject ? "R9 compare count" : "R6 compare count", n_starts, es);
    check(bad_seq == 0, "R2/R6 level sequence", bad_seq, 0);
    check(bad_stab == 0, "R3/R4 level stability", bad_stab, 0);
    check(bad_pulse == 0, "R3 start pulse width", bad_pulse, 0);
    // done is a single pulse and the result is held afterwards (R8)
    for (int i = 0; i < 3; i++) @(negedge clk);
    in_search = 0;
    check(n_done == 1, "R8 done count", n_done, 1);
    check(!done_o, "R8 done low", int'(done_o), 0);
    check(int'(code_o) == ec, "R8 code held", int'(code_o), ec);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(code_o == 4'd0, "R1 code reset", int'(code_o), 0);
    check(!underflow_o, "R1 underflow reset", int'(underflow_o), 0);
    check(!done_o && !cmp_start_o, "R1 done/start reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmp_start_o && !done_o, "R1 idle after reset", int'(cmp_start_o), 0);
    run_search(16, 0, 0);   // R2/R5 pass at top code
    run_search(15, 2, 0);   // R6 one step down
    run_search(2, 1, 0);    // R5 pass at code 1
    run_search(1, 0, 0);    // R7 underflow at edge
    run_search(0, 3, 1);    // R7 underflow with R9 injection
    run_search(9, 6, 1);    // R4 long busy, R9
    for (int t = 0; t < 24; t++)
      run_search(int'($urandom_range(0, 18)), int'($urandom_range(0, 5)), t[0]);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end
endmodule